// File: doc/BRIEF.md
# Bit-Banged Two-Wire Pin Register

This block is a pair of general-purpose I/O registers that sit in a host-visible register file: a pin value register and a pin direction register. The two lowest pins carry a two-wire serial bus. Bit 0 is the data line and bit 1 is the clock line. Host software runs the bus by writing the value and direction registers and by polling the read port. Each line is open-drain, so the block either pulls a line low or lets it float.

A read of the value register does not return the stored byte as written. It returns the stored value, cleared wherever the direction register marks a pin as an input, and limited to the five low bits. Each bus pin can also be switched so that its read bit shows the live level on the line. That happens when its direction bit is set and a gate bit in the upper part of the direction register is clear: bit 6 gates the data line and bit 7 gates the clock line.

Top module: `gpio_twowire_pins`

## Requirements
- R1: After reset the value register holds 0x00 and the direction register holds 0x03. Both lines are released (`sda_pull_low` = 0, `scl_pull_low` = 0), and a read of the direction register returns 0x03.
- R2: A write with `wr_en` = 1 and `wr_sel` = 1 stores the whole byte in the direction register. A later read with `rd_sel` = 1 returns that byte unchanged.
- R3: A line is pulled low only when its direction bit is 0 and its value bit is 0. The data line uses bit 0 of each register and the clock line uses bit 1. In every other case the line is released.
- R4: A read with `rd_sel` = 0 returns value & ~direction on bits 4..0, and 0 on bits 7..5, except where R5 or R6 applies.
- R5: When direction bit 0 is 1 and direction bit 6 is 0, bit 0 of a value-register read is the live level of `sda_in`.
- R6: When direction bit 1 is 1 and direction bit 7 is 0, bit 1 of a value-register read is the live level of `scl_in`.
- R7: A write takes effect at the clock edge that samples it. A read in the same cycle as the write returns the contents from before the write.
- R8: With `wr_en` = 0, the values on `wr_sel` and `wr_data` change neither register and neither line drive.
- R9: A write with `wr_en` = 1 and `wr_sel` = 0 stores the whole byte in the value register. The stored bits 1..0 drive the lines as R3 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 value register, 1 direction register |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Read source: 0 value register (mixed with the line levels), 1 direction register |
| rd_data | output | 8 | Read data, combinational from the register state and the line levels |
| sda_in | input | 1 | Sensed level of the data line |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_pull_low | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_pull_low | output | 1 | 1 pulls the clock line low, 0 releases it |

## Verification
A register write and a read of the same register can fall in the same cycle. The read must then show the contents from before the edge, and the new contents must appear only on the following cycle. The bench sets up this collision on purpose by writing the direction register while reading it back. It also changes the line levels in the same cycle as a direction write that turns live sensing on or off. A software model that updates only at the clock edge decides each result.

// File: rtl/gpio_twowire_pkg.sv
package gpio_twowire_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned SDA_IDX    = 0;
   localparam int unsigned SCL_IDX    = 1;
   localparam int unsigned BUS_PINS   = 2;

   typedef enum logic {
      SEL_VALUE = 1'b0,
      SEL_DIR   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/gpio_twowire_regs.sv
module gpio_twowire_regs
   import gpio_twowire_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter logic [W-1:0] VAL_RST  = '0,
   parameter logic [W-1:0] DIR_RST  = 8'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] val_q,
   output logic [W-1:0] dir_q
);
   generate
      if (W < 8) begin : g_bad_width
         $error("gpio_twowire_regs: W must be at least 8");
      end
   endgenerate

   logic wr_val, wr_dir;
   assign wr_val = wr_en && (reg_sel_e'(wr_sel) == SEL_VALUE);
   assign wr_dir = wr_en && (reg_sel_e'(wr_sel) == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= VAL_RST;
         dir_q <= DIR_RST;
      end else begin
         if (wr_val) val_q <= wr_data;
         if (wr_dir) dir_q <= wr_data;
      end
   end
endmodule

// File: rtl/gpio_twowire_drive.sv
module gpio_twowire_drive #(
   parameter int unsigned W    = 8,
   parameter int unsigned PINS = 2
) (
   input  logic [W-1:0]    val_q,
   input  logic [W-1:0]    dir_q,
   output logic [PINS-1:0] pull_low
);
   generate
      if (PINS > W) begin : g_bad_pins
         $error("gpio_twowire_drive: PINS exceeds register width");
      end
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         // Output mode and a low value: sink the line; otherwise float.
         assign pull_low[p] = !dir_q[p] && !val_q[p];
      end
   endgenerate
endmodule

// File: rtl/gpio_twowire_readback.sv
module gpio_twowire_readback #(
   parameter int unsigned W          = 8,
   parameter int unsigned VIS_BITS   = 5,
   parameter int unsigned PINS       = 2,
   parameter int unsigned GATE_BASE  = 6
) (
   input  logic [W-1:0]    val_q,
   input  logic [W-1:0]    dir_q,
   input  logic [PINS-1:0] live,
   input  logic            rd_sel,
   output logic [W-1:0]    rd_data
);
   localparam logic [W-1:0] VIS_MASK = W'((1 << VIS_BITS) - 1);

   generate
      if (GATE_BASE + PINS > W) begin : g_bad_gate
         $error("gpio_twowire_readback: gate bits exceed register width");
      end
      if (VIS_BITS < PINS || VIS_BITS > W) begin : g_bad_vis
         $error("gpio_twowire_readback: VIS_BITS out of range");
      end
   endgenerate

   logic [W-1:0]    base;
   logic [PINS-1:0] sense_on;
   logic [W-1:0]    mixed;

   assign base = val_q & ~dir_q & VIS_MASK;

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_sense
         assign sense_on[p] = dir_q[p] && !dir_q[GATE_BASE + p];
      end
   endgenerate

   always_comb begin
      mixed = base;
      for (int p = 0; p < PINS; p++) begin
         if (sense_on[p]) mixed[p] = live[p];
      end
      rd_data = rd_sel ? dir_q : mixed;
   end
endmodule

// File: rtl/gpio_twowire_pins.sv
module gpio_twowire_pins
   import gpio_twowire_pkg::*;
#(
   parameter int unsigned W         = REG_W,
   parameter logic [W-1:0] VAL_RST  = '0,
   parameter logic [W-1:0] DIR_RST  = 8'h03,
   parameter int unsigned VIS_BITS  = 5,
   parameter int unsigned GATE_BASE = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         rd_sel,
   output logic [W-1:0] rd_data,
   input  logic         sda_in,
   input  logic         scl_in,
   output logic         sda_pull_low,
   output logic         scl_pull_low
);
   logic [W-1:0]        val_q, dir_q;
   logic [BUS_PINS-1:0] pull_low;
   logic [BUS_PINS-1:0] live;

   assign live[SDA_IDX] = sda_in;
   assign live[SCL_IDX] = scl_in;

   gpio_twowire_regs #(.W(W), .VAL_RST(VAL_RST), .DIR_RST(DIR_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .val_q(val_q), .dir_q(dir_q)
   );

   gpio_twowire_drive #(.W(W), .PINS(BUS_PINS)) u_drive (
      .val_q(val_q), .dir_q(dir_q), .pull_low(pull_low)
   );

   gpio_twowire_readback #(.W(W), .VIS_BITS(VIS_BITS), .PINS(BUS_PINS),
                           .GATE_BASE(GATE_BASE)) u_rb (
      .val_q(val_q), .dir_q(dir_q), .live(live), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   assign sda_pull_low = pull_low[SDA_IDX];
   assign scl_pull_low = pull_low[SCL_IDX];
endmodule

// File: rtl/gpio_twowire_checker.sv
module gpio_twowire_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_sel,
   input logic [7:0] wr_data,
   input logic       rd_sel,
   input logic [7:0] rd_data,
   input logic       sda_in,
   input logic       scl_in,
   input logic       sda_pull_low,
   input logic       scl_pull_low,
   input logic [7:0] dir_q,
   input logic [7:0] val_q
);
   assert_sda_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && rd_data[0]) |-> !sda_pull_low);
   assert_scl_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && rd_data[1]) |-> !scl_pull_low);
   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_sel |-> (rd_data[7:5] == 3'b000));
   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (!rd_sel || rd_data == $past(wr_data)));
   assert_sda_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel && dir_q[0] && !dir_q[6]) |-> (rd_data[0] == sda_in));
   assert_scl_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel && dir_q[1] && !dir_q[7]) |-> (rd_data[1] == scl_in));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(dir_q) && $stable(val_q)));
endmodule

bind gpio_twowire_pins gpio_twowire_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .rd_sel(rd_sel), .rd_data(rd_data), .sda_in(sda_in), .scl_in(scl_in),
   .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low),
   .dir_q(dir_q), .val_q(val_q)
);

// File: tb/sim_gpio_twowire_pins.sv
`timescale 1ns/1ps
module sim_gpio_twowire_pins;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       sda_in = 1'b1, scl_in = 1'b1;
   logic       sda_pull_low, scl_pull_low;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_val, m_dir;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_twowire_pins u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .sda_in(sda_in), .scl_in(scl_in),
      .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low)
   );

   function automatic logic [7:0] exp_read(logic sel, logic [7:0] v, logic [7:0] d,
                                           logic sda, logic scl);
      logic [7:0] r;
      if (sel) return d;
      r = v & ~d & 8'h1F;
      if (d[0] && !d[6]) r[0] = sda;
      if (d[1] && !d[7]) r[1] = scl;
      return r;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Compare all outputs against the model (call mid-cycle).
   task automatic check_all(string tag);
      check({tag, " read"}, rd_data, exp_read(rd_sel, m_val, m_dir, sda_in, scl_in));
      check("R3 sda drive", {7'd0, sda_pull_low}, {7'd0, !m_dir[0] && !m_val[0]});
      check("R3 scl drive", {7'd0, scl_pull_low}, {7'd0, !m_dir[1] && !m_val[1]});
   endtask

   // Drive one cycle at negedge, check before posedge, update model at posedge.
   task automatic cycle(logic en, logic ws, logic [7:0] wd, logic rs,
                        logic sda, logic scl, string tag);
      @(negedge clk);
      wr_en = en; wr_sel = ws; wr_data = wd; rd_sel = rs; sda_in = sda; scl_in = scl;
      #5 check_all(tag);
      @(posedge clk);
      if (en) begin
         if (ws) m_dir = wd; else m_val = wd;
      end
   endtask

   initial begin
      m_val = 8'h00; m_dir = 8'h03;
      #35 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk); rd_sel = 1'b1; #1;
      check("R1 dir reset", rd_data, 8'h03);
      check("R1 pulls", {6'd0, scl_pull_low, sda_pull_low}, 8'h00);
      cycle(0, 0, 8'h00, 0, 1, 0, "R1 val reset");
      // R9 value write, R3 drive low
      cycle(1, 0, 8'hFC, 0, 1, 1, "R9 write");
      cycle(1, 1, 8'h00, 0, 1, 1, "R2 dir to outputs");
      cycle(0, 0, 8'h00, 0, 0, 0, "R4 base");
      // R7: write dir and read it in the same cycle -> old value
      @(negedge clk);
      wr_en = 1; wr_sel = 1; wr_data = 8'hA5; rd_sel = 1; #5;
      check("R7 same-cycle read", rd_data, m_dir);
      @(posedge clk); m_dir = 8'hA5;
      @(negedge clk); wr_en = 0; #5;
      check("R7 next-cycle read", rd_data, 8'hA5);
      @(posedge clk);
      // R8 ignored write
      cycle(0, 1, 8'h5A, 1, 0, 1, "R8 ignored dir");
      cycle(0, 0, 8'hFF, 0, 0, 1, "R8 ignored val");
      // R5/R6 live sensing, gate bits on and off
      cycle(1, 1, 8'h03, 0, 0, 1, "R2 sense on");
      cycle(0, 0, 8'h00, 0, 0, 1, "R5 R6 live");
      cycle(0, 0, 8'h00, 0, 1, 0, "R5 R6 live flip");
      cycle(1, 1, 8'hC3, 0, 1, 1, "R6 gate write");
      cycle(0, 0, 8'h00, 0, 1, 1, "R5 R6 gated");
      cycle(1, 1, 8'h43, 0, 1, 1, "R6 scl only");
      cycle(0, 0, 8'h00, 0, 0, 1, "R6 scl live");
      // Random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         cycle(r[0], r[1], 8'($urandom), r[2], r[3], r[4], "R4 R5 R6 random");
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule